// File: doc/BRIEF.md
# Partition Access Guard

This block sits between a host port and a flash-backed address space and decides, on every host access cycle, whether the access may proceed. It holds two programmable address windows. Each window has inclusive lower and upper bounds and four attribute bits: deny reads, deny writes, guard by key, and guard by the hardware lock input. An access that falls inside a window that is currently locked and whose attribute denies that direction is blocked. A blocked read returns all-ones to the host. A blocked write never reaches the memory write enable.

A window guarded by key is opened when the host presents the matching 64-bit key for that window. The reference keys come from outside the block. The open state is withdrawn again by any of three events: a power-down pulse, a change to any window's attribute bits, or a host write into the initial-program-load region at the bottom of the address space. A window guarded by the lock input stays closed while that input is high, whatever the key state. Every blocked access sets an interrupt flag, which the host clears with an acknowledge pulse.

Top module: `ppu_guard`

## Requirements
- R1: Configuration is written through `cfg_we`/`cfg_addr`/`cfg_wdata` and takes effect from the next cycle. `cfg_addr[2]` selects window 0 or 1. `cfg_addr[1:0]` selects the field: 0 is the lower bound, 1 is the upper bound, 2 is the attribute, and 3 is ignored. Both bounds are inclusive.
- R2: An access inside a locked window whose attribute denies its direction is blocked in the same cycle. A blocked read drives `acc_rdata` to all-ones, and a blocked write holds `mem_we` low. Any other access passes `mem_rdata` through, and a write raises `mem_we`.
- R3: The attribute bits are: bit0 deny read, bit1 deny write, bit2 key guard, bit3 lock-input guard. A window is locked when it is key-guarded and not opened, or when it is lock-guarded and `hw_lock` is high. A window with neither guard bit never blocks.
- R4: Presenting the correct key (`key_valid`, `key_sel`, `key_word` equal to that window's slice of `ref_keys`) for a key-guarded window opens it from the next cycle. While `hw_lock` is high, a window that is also lock-guarded stays blocked.
- R5: A wrong key changes nothing. It neither opens a closed window nor closes an open one.
- R6: A `pwr_down` pulse closes both windows from the next cycle.
- R7: An attribute write whose value differs from the stored one closes both windows. Rewriting the same attribute value, or writing a bound, leaves the open state alone.
- R8: A host write to an address below `IPL_WORDS` (64 by default) closes both windows from the next cycle.
- R9: `irq` goes high the cycle after any blocked access and stays high until `irq_ack`. A blocked access in the same cycle as `irq_ack` wins.
- R10: Reset clears all bounds and attributes to zero, closes both windows and drives `irq` low, so that no access is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Window select and field select |
| cfg_wdata | input | 16 | Configuration data |
| ref_keys | input | 128 | Reference keys, window 0 in the low 64 bits |
| key_valid | input | 1 | Key presentation strobe |
| key_sel | input | 1 | Window the key is meant for |
| key_word | input | 64 | Presented key |
| hw_lock | input | 1 | Hardware lock, high forces lock-guarded windows closed |
| pwr_down | input | 1 | Power-down event pulse |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 16 | Access address |
| mem_rdata | input | 16 | Read data from the array |
| acc_rdata | output | 16 | Read data to the host |
| mem_we | output | 1 | Write enable to the array |
| irq | output | 1 | Violation interrupt flag |
| irq_ack | input | 1 | Clears the interrupt flag |

## Verification
The bench probes the exact bound addresses on both sides. A design that used exclusive bounds would let the first or last word through. It presents wrong keys both before and after a correct one. A design that treated a mismatch as a reset of the open state would close a window it should leave open. It rewrites an attribute with its own value and then with a new value. A design that revoked on every attribute write, or only on changes to the same window, would give the wrong block pattern on the other window. It also opens a window that is guarded by both key and lock while `hw_lock` is high, and it fires `irq_ack` in the same cycle as a violation. A design with the wrong precedence in either case would let a write through or lose an interrupt.

// File: rtl/ppu_pkg.sv
package ppu_pkg;
   typedef struct packed {
      logic hw_en;
      logic key_en;
      logic wr_deny;
      logic rd_deny;
   } ppu_attr_t;

   localparam logic [1:0] FLD_LO   = 2'd0;
   localparam logic [1:0] FLD_HI   = 2'd1;
   localparam logic [1:0] FLD_ATTR = 2'd2;
endpackage

// File: rtl/ppu_region.sv
module ppu_region
   import ppu_pkg::*;
#(
   parameter int AW = 16,
   parameter int KW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_sel,
   input  logic [1:0]    cfg_field,
   input  logic [AW-1:0] cfg_wdata,
   input  logic [KW-1:0] ref_key,
   input  logic          key_hit,
   input  logic [KW-1:0] key_word,
   input  logic          revoke,
   input  logic          hw_lock,
   input  logic          acc_valid,
   input  logic          acc_write,
   input  logic [AW-1:0] acc_addr,
   output logic          viol,
   output logic          attr_chg
);
   logic [AW-1:0] lo_q, hi_q;
   ppu_attr_t     attr_q;
   logic          open_q;
   logic          in_rng, locked, key_ok, wr_cfg;

   assign wr_cfg   = cfg_we && cfg_sel;
   assign key_ok   = key_hit && (key_word == ref_key);
   assign attr_chg = wr_cfg && (cfg_field == FLD_ATTR) && (ppu_attr_t'(cfg_wdata[3:0]) != attr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         attr_q <= '0;
         open_q <= 1'b0;
      end else begin
         if (wr_cfg) begin
            case (cfg_field)
               FLD_LO:   lo_q   <= cfg_wdata;
               FLD_HI:   hi_q   <= cfg_wdata;
               FLD_ATTR: attr_q <= ppu_attr_t'(cfg_wdata[3:0]);
               default:  ;
            endcase
         end
         if (revoke)
            open_q <= 1'b0;
         else if (key_ok && attr_q.key_en)
            open_q <= 1'b1;
      end
   end

   always_comb begin
      in_rng = (acc_addr >= lo_q) && (acc_addr <= hi_q);
      locked = (attr_q.key_en && !open_q) || (attr_q.hw_en && hw_lock);
      viol   = acc_valid && in_rng && locked &&
               (acc_write ? attr_q.wr_deny : attr_q.rd_deny);
   end

   // R4 R5
   open_only_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(key_ok));

   // R6 R7 R8
   revoke_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      revoke |=> !open_q);
endmodule

// File: rtl/ppu_irq.sv
module ppu_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic viol_any,
   input  logic irq_ack,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         irq <= 1'b0;
      else if (viol_any)
         irq <= 1'b1;
      else if (irq_ack)
         irq <= 1'b0;
   end

   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(viol_any));

   // R9
   irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_any |=> irq);
endmodule

// File: rtl/ppu_guard.sv
module ppu_guard
   import ppu_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int KW        = 64,
   parameter int NPART     = 2,
   parameter int IPL_WORDS = 64,
   localparam int PSW      = $clog2(NPART),
   localparam int CAW      = PSW + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CAW-1:0]      cfg_addr,
   input  logic [AW-1:0]       cfg_wdata,
   input  logic [NPART*KW-1:0] ref_keys,
   input  logic                key_valid,
   input  logic [PSW-1:0]      key_sel,
   input  logic [KW-1:0]       key_word,
   input  logic                hw_lock,
   input  logic                pwr_down,
   input  logic                acc_valid,
   input  logic                acc_write,
   input  logic [AW-1:0]       acc_addr,
   input  logic [DW-1:0]       mem_rdata,
   output logic [DW-1:0]       acc_rdata,
   output logic                mem_we,
   output logic                irq,
   input  logic                irq_ack
);
   if (NPART < 2) begin : g_bad_npart
      $error("ppu_guard: NPART must be at least 2");
   end
   if (AW < 4) begin : g_bad_aw
      $error("ppu_guard: AW must hold the 4 attribute bits");
   end

   logic [NPART-1:0] viol_v, chg_v;
   logic             viol_any, ipl_wr, revoke;

   if (IPL_WORDS > 0) begin : g_ipl
      assign ipl_wr = acc_valid && acc_write && (acc_addr < AW'(IPL_WORDS));
   end else begin : g_no_ipl
      assign ipl_wr = 1'b0;
   end

   assign revoke   = pwr_down || (|chg_v) || ipl_wr;
   assign viol_any = |viol_v;

   for (genvar g = 0; g < NPART; g++) begin : g_part
      ppu_region #(.AW(AW), .KW(KW)) i_region (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we),
         .cfg_sel   (cfg_addr[CAW-1:2] == PSW'(g)),
         .cfg_field (cfg_addr[1:0]),
         .cfg_wdata (cfg_wdata),
         .ref_key   (ref_keys[g*KW +: KW]),
         .key_hit   (key_valid && (key_sel == PSW'(g))),
         .key_word  (key_word),
         .revoke    (revoke),
         .hw_lock   (hw_lock),
         .acc_valid (acc_valid),
         .acc_write (acc_write),
         .acc_addr  (acc_addr),
         .viol      (viol_v[g]),
         .attr_chg  (chg_v[g])
      );
   end

   assign mem_we    = acc_valid && acc_write && !viol_any;
   assign acc_rdata = (acc_valid && !acc_write && viol_any) ? '1 : mem_rdata;

   ppu_irq i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .viol_any (viol_any),
      .irq_ack  (irq_ack),
      .irq      (irq)
   );

   // R2
   blocked_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_any && !acc_write) |-> (acc_rdata == {DW{1'b1}}));

   // R2
   blocked_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_any |-> !mem_we);
endmodule

// File: tb/test_ppu_guard.sv
module test_ppu_guard;
   localparam logic [63:0] K0 = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] K1 = 64'hFEDC_BA98_7654_3210;
   localparam logic [15:0] MEMV = 16'h5A5A;
   // {write, expect_blocked, addr}
   localparam logic [17:0] VEC [8] = '{
      {1'b0, 1'b0, 16'h00FF}, {1'b0, 1'b1, 16'h0100},
      {1'b1, 1'b1, 16'h01FF}, {1'b0, 1'b0, 16'h0200},
      {1'b0, 1'b0, 16'h0300}, {1'b1, 1'b1, 16'h03FF},
      {1'b1, 1'b0, 16'h0400}, {1'b1, 1'b0, 16'h02FF}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0, key_valid = 1'b0, key_sel = 1'b0;
   logic hw_lock = 1'b0, pwr_down = 1'b0, irq_ack = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0, acc_addr = '0;
   logic [63:0] key_word = '0;
   logic [15:0] acc_rdata;
   logic        mem_we, irq;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ppu_guard i_ppu_guard (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .ref_keys({K1, K0}), .key_valid(key_valid),
      .key_sel(key_sel), .key_word(key_word), .hw_lock(hw_lock),
      .pwr_down(pwr_down), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .mem_rdata(MEMV), .acc_rdata(acc_rdata),
      .mem_we(mem_we), .irq(irq), .irq_ack(irq_ack));

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cfg(logic [2:0] a, logic [15:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic key(logic s, logic [63:0] k);
      @(negedge clk); key_valid = 1'b1; key_sel = s; key_word = k;
      @(negedge clk); key_valid = 1'b0;
   endtask

   task automatic acc(logic wr, logic [15:0] a, logic blk, string req);
      @(negedge clk); acc_valid = 1'b1; acc_write = wr; acc_addr = a;
      #1;
      if (wr) check(mem_we == !blk, req, {31'd0, mem_we}, {31'd0, !blk});
      else    check(acc_rdata == (blk ? 16'hFFFF : MEMV), req,
                    {16'd0, acc_rdata}, {16'd0, blk ? 16'hFFFF : MEMV});
      @(negedge clk); acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq == 1'b0, "R10 irq after reset", {31'd0, irq}, 32'd0);
      acc(1'b0, 16'h0000, 1'b0, "R10 nothing blocked after reset");
      // window 0: 0x100..0x1FF deny rd+wr, key guard; window 1: 0x300..0x3FF deny wr, lock guard
      cfg(3'd0, 16'h0100); cfg(3'd1, 16'h01FF); cfg(3'd2, 16'h0007);
      cfg(3'd4, 16'h0300); cfg(3'd5, 16'h03FF); cfg(3'd6, 16'h000A);
      hw_lock = 1'b1;
      for (int i = 0; i < 8; i++)
         acc(VEC[i][17], VEC[i][15:0], VEC[i][16], "R1 R2 R3 table");
      check(irq == 1'b1, "R9 irq after violation", {31'd0, irq}, 32'd1);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      check(irq == 1'b0, "R9 irq cleared by ack", {31'd0, irq}, 32'd0);
      @(negedge clk); irq_ack = 1'b1; acc_valid = 1'b1; acc_addr = 16'h0100;
      @(negedge clk); irq_ack = 1'b0; acc_valid = 1'b0;
      check(irq == 1'b1, "R9 violation beats ack", {31'd0, irq}, 32'd1);
      key(1'b0, K1);
      acc(1'b0, 16'h0100, 1'b1, "R5 wrong key stays closed");
      key(1'b0, K0);
      acc(1'b0, 16'h0100, 1'b0, "R4 key opens read");
      acc(1'b1, 16'h0150, 1'b0, "R4 key opens write");
      key(1'b0, 64'hDEAD);
      acc(1'b0, 16'h01FF, 1'b0, "R5 wrong key keeps open");
      cfg(3'd6, 16'h000A); cfg(3'd4, 16'h0300);
      acc(1'b0, 16'h0100, 1'b0, "R7 same attr and bound keep open");
      cfg(3'd6, 16'h0002);
      acc(1'b0, 16'h0100, 1'b1, "R7 attr change closes other window");
      acc(1'b1, 16'h0300, 1'b0, "R3 unguarded window never blocks");
      cfg(3'd6, 16'h000A);
      key(1'b0, K0);
      acc(1'b1, 16'h0010, 1'b0, "R8 IPL write itself passes");
      acc(1'b0, 16'h0100, 1'b1, "R8 IPL write closes");
      key(1'b0, K0);
      acc(1'b0, 16'h0100, 1'b0, "R6 open before power-down");
      @(negedge clk); pwr_down = 1'b1;
      @(negedge clk); pwr_down = 1'b0;
      acc(1'b0, 16'h0100, 1'b1, "R6 power-down closes");
      cfg(3'd6, 16'h000E);
      key(1'b1, K1);
      acc(1'b1, 16'h0300, 1'b1, "R4 lock input overrides key");
      hw_lock = 1'b0;
      acc(1'b1, 16'h0300, 1'b0, "R4 key open once lock drops");
      cfg(3'd6, 16'h000A);
      acc(1'b1, 16'h03FF, 1'b0, "R3 lock guard, lock low");
      hw_lock = 1'b1;
      acc(1'b1, 16'h03FF, 1'b1, "R3 lock guard, lock high");
      cfg(3'd1, 16'h017F);
      acc(1'b0, 16'h017F, 1'b1, "R1 new upper bound inclusive");
      acc(1'b0, 16'h0180, 1'b0, "R1 above new upper bound");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule